// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block decides whether the local device is being addressed on an I2C or SMBus bus. It looks at the bytes that arrive after a start or repeated-start condition, one byte per `byte_vld` pulse, and compares them against a parameterised number of address slots. Each slot is switched on and off separately and works in either 7-bit or 10-bit format. The two formats may be mixed freely across the slots. Three reserved addresses are recognised as well, each behind its own enable: the general call, the device ID address and the SMBus host address.

A bit engine sits beside the matcher. It pulses `start_det` on every start or repeated start and passes in each completed byte. On an address byte that must be acknowledged, the matcher returns a one-cycle `ack_req`. The match result stays on `match_valid`, `match_idx` and `match_rd` until the next start. A 10-bit address takes two bytes. If the bus repeats a start and sends a read header for the 10-bit address that matched last, this turns the transfer into a slave-transmit transfer without the low address byte being sent again.

Index codes are fixed relative to the slot count N, which defaults to 3:
- slots use 0 to N-1;
- general call is N;
- device ID is N+1;
- SMBus host is N+2;
- no match is all ones (7 at the default).

Top module: `i2c_addr_matcher`

## Requirements
- R1: After reset, `match_valid`=0, `match_idx`=7 (no match), `match_rd`=0 and `ack_req`=0. Bytes that arrive before the first `start_det` raise no acknowledge and no match.
- R2: A 7-bit slot matches on the first byte after a start when three conditions hold: the slot is enabled, its format bit is 0, and byte bits [7:1] equal the slot address bits [6:0]. On a match, `match_valid`=1, `match_idx` gives the slot number and `match_rd`=byte bit 0. `ack_req` pulses in the cycle after the byte.
- R3: A 10-bit slot (format bit 1) treats a first byte of 11110, then address bits [9:8], then 0 as a header. The header is acknowledged without a match. A following second byte equal to address bits [7:0] gives a match with `match_rd`=0 and an acknowledge. Any other second byte gives neither.
- R4: A 10-bit match is remembered only until the next first byte. If that next first byte is 11110, then the remembered slot's bits [9:8], then 1, it gives a match on that slot with `match_rd`=1 and an acknowledge. Any other first byte clears the memory.
- R5: A disabled slot never matches.
- R6: When several slots match, the lowest slot number is reported. Slots take precedence over reserved addresses.
- R7: With the general call enabled, a first byte of 0x00 matches with code N (3) and `match_rd`=0. A first byte of 0x01 does not match it.
- R8: With the device ID enabled, a first byte whose bits [7:1] are 1111100 matches with code N+1 (4), and `match_rd`=bit 0.
- R9: With the SMBus host address enabled, a first byte of 0x10 matches with code N+2 (5). A first byte of 0x11 does not.
- R10: `start_det` clears `match_valid`, sets `match_idx` to 7 and clears `match_rd`. Bytes after the address phase raise no acknowledge and leave the match outputs unchanged until the next start.
- R11: A `start_det` in the same cycle as `byte_vld` wins, and that byte is discarded.
- R12: `ack_req` is a single-cycle pulse. It appears only in the cycle after an acknowledged address byte and never for a byte that matches nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_det | input | 1 | Start or repeated start seen on the bus |
| byte_vld | input | 1 | A received byte is present on `byte_data` |
| byte_data | input | 8 | Received byte, bit 0 is the read/write bit |
| slot_en | input | NUM_SLOTS | Per-slot enable |
| slot_ten | input | NUM_SLOTS | Per-slot format: 1 = 10-bit, 0 = 7-bit |
| slot_addr | input | NUM_SLOTS*10 | Slot addresses, slot i in bits [10*i+9:10*i] |
| gc_en | input | 1 | General call detection enable |
| devid_en | input | 1 | Device ID detection enable |
| host_en | input | 1 | SMBus host address detection enable |
| match_valid | output | 1 | Address phase produced a match |
| match_idx | output | IDX_W | Matched slot or reserved code, all ones when none |
| match_rd | output | 1 | Direction of the matched transfer, 1 = read |
| ack_req | output | 1 | One-cycle request to acknowledge the last byte |

## Verification
The bench builds the matcher with the default of three slots. This makes the codes 0 to 2 for slots, 3 to 5 for the reserved addresses and 7 for no match, and it lets one configuration hold 7-bit and 10-bit slots side by side. With three slots the bench can give two slots the same address, so it can exercise lowest-slot priority, slot-over-reserved precedence and the 10-bit read resume on a slot that is not slot 0. Random configurations, biased towards header and reserved bytes, then cover the interplay of memory, candidates and reserved codes.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

    typedef enum logic [1:0] {
        PH_DONE  = 2'd0,
        PH_FIRST = 2'd1,
        PH_LOW   = 2'd2
    } am_phase_e;

    localparam logic [4:0] TEN_HDR   = 5'b11110;
    localparam logic [6:0] DEVID_7   = 7'b1111100;
    localparam logic [6:0] SMBHOST_7 = 7'b0001000;
    localparam int         SLOT_W    = 10;

endpackage

// File: rtl/am_slot_cmp.sv
module am_slot_cmp
    import i2c_am_pkg::*;
(
    input  logic              en,
    input  logic              ten,
    input  logic [SLOT_W-1:0] addr,
    input  logic [7:0]        rx_byte,
    output logic              hit7,
    output logic              hdr_hit,
    output logic              low_hit
);
    always_comb begin
        hit7    = en && !ten && (rx_byte[7:1] == addr[6:0]);
        hdr_hit = en && ten && (rx_byte[7:3] == TEN_HDR) && (rx_byte[2:1] == addr[9:8]);
        low_hit = en && ten && (rx_byte == addr[7:0]);
    end
endmodule

// File: rtl/am_rsvd_det.sv
module am_rsvd_det
    import i2c_am_pkg::*;
(
    input  logic [7:0] rx_byte,
    input  logic       gc_en,
    input  logic       devid_en,
    input  logic       host_en,
    output logic       gc_hit,
    output logic       dev_hit,
    output logic       host_hit
);
    always_comb begin
        gc_hit   = gc_en && (rx_byte == 8'h00);
        dev_hit  = devid_en && (rx_byte[7:1] == DEVID_7);
        host_hit = host_en && (rx_byte == {SMBHOST_7, 1'b0});
    end
endmodule

// File: rtl/am_prio.sv
module am_prio #(
    parameter int N     = 3,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/i2c_addr_matcher.sv
module i2c_addr_matcher
    import i2c_am_pkg::*;
#(
    parameter int NUM_SLOTS = 3,
    localparam int IDX_W    = $clog2(NUM_SLOTS + 4)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_det,
    input  logic                        byte_vld,
    input  logic [7:0]                  byte_data,
    input  logic [NUM_SLOTS-1:0]        slot_en,
    input  logic [NUM_SLOTS-1:0]        slot_ten,
    input  logic [NUM_SLOTS*SLOT_W-1:0] slot_addr,
    input  logic                        gc_en,
    input  logic                        devid_en,
    input  logic                        host_en,
    output logic                        match_valid,
    output logic [IDX_W-1:0]            match_idx,
    output logic                        match_rd,
    output logic                        ack_req
);
    localparam logic [IDX_W-1:0] CODE_GC   = IDX_W'(NUM_SLOTS);
    localparam logic [IDX_W-1:0] CODE_DEV  = IDX_W'(NUM_SLOTS + 1);
    localparam logic [IDX_W-1:0] CODE_HOST = IDX_W'(NUM_SLOTS + 2);
    localparam logic [IDX_W-1:0] CODE_NONE = '1;

    typedef struct packed {
        am_phase_e              phase;
        logic                   match;
        logic [IDX_W-1:0]       idx;
        logic                   rd;
        logic                   ack;
        logic [NUM_SLOTS-1:0]   cand;
        logic                   mem_v;
        logic [IDX_W-1:0]       mem_idx;
    } am_state_t;

    am_state_t st_d, st_q;

    logic [NUM_SLOTS-1:0] hit7_v, hdr_v, low_v, resume_v, first_v, second_v;
    logic gc_hit, dev_hit, host_hit;
    logic first_any, second_any;
    logic [IDX_W-1:0] first_idx, second_idx;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        am_slot_cmp u_cmp (
            .en      (slot_en[g]),
            .ten     (slot_ten[g]),
            .addr    (slot_addr[g*SLOT_W +: SLOT_W]),
            .rx_byte (byte_data),
            .hit7    (hit7_v[g]),
            .hdr_hit (hdr_v[g]),
            .low_hit (low_v[g])
        );
        assign resume_v[g] = hdr_v[g] && byte_data[0] && st_q.mem_v
                             && (st_q.mem_idx == IDX_W'(g));
    end

    assign first_v  = hit7_v | resume_v;
    assign second_v = low_v & st_q.cand;

    am_rsvd_det u_rsvd (
        .rx_byte  (byte_data),
        .gc_en    (gc_en),
        .devid_en (devid_en),
        .host_en  (host_en),
        .gc_hit   (gc_hit),
        .dev_hit  (dev_hit),
        .host_hit (host_hit)
    );

    am_prio #(.N(NUM_SLOTS), .IDX_W(IDX_W)) u_prio_first (
        .req   (first_v),
        .found (first_any),
        .idx   (first_idx)
    );

    am_prio #(.N(NUM_SLOTS), .IDX_W(IDX_W)) u_prio_second (
        .req   (second_v),
        .found (second_any),
        .idx   (second_idx)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ack = 1'b0;
        if (start_det) begin
            st_d.phase = PH_FIRST;
            st_d.match = 1'b0;
            st_d.idx   = CODE_NONE;
            st_d.rd    = 1'b0;
            st_d.cand  = '0;
        end else if (byte_vld) begin
            unique case (st_q.phase)
                PH_FIRST: begin
                    st_d.phase = PH_DONE;
                    st_d.mem_v = 1'b0;
                    st_d.cand  = '0;
                    if (first_any) begin
                        st_d.match = 1'b1;
                        st_d.idx   = first_idx;
                        st_d.rd    = byte_data[0];
                        st_d.ack   = 1'b1;
                        st_d.mem_v = |(resume_v & first_v & ~(first_v - 1'b1));
                    end else if (gc_hit) begin
                        st_d.match = 1'b1;
                        st_d.idx   = CODE_GC;
                        st_d.rd    = 1'b0;
                        st_d.ack   = 1'b1;
                    end else if (dev_hit) begin
                        st_d.match = 1'b1;
                        st_d.idx   = CODE_DEV;
                        st_d.rd    = byte_data[0];
                        st_d.ack   = 1'b1;
                    end else if (host_hit) begin
                        st_d.match = 1'b1;
                        st_d.idx   = CODE_HOST;
                        st_d.rd    = 1'b0;
                        st_d.ack   = 1'b1;
                    end else if (!byte_data[0] && (|hdr_v)) begin
                        st_d.phase = PH_LOW;
                        st_d.cand  = hdr_v;
                        st_d.ack   = 1'b1;
                    end
                end
                PH_LOW: begin
                    st_d.phase = PH_DONE;
                    st_d.cand  = '0;
                    if (second_any) begin
                        st_d.match   = 1'b1;
                        st_d.idx     = second_idx;
                        st_d.rd      = 1'b0;
                        st_d.ack     = 1'b1;
                        st_d.mem_v   = 1'b1;
                        st_d.mem_idx = second_idx;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase   <= PH_DONE;
            st_q.match   <= 1'b0;
            st_q.idx     <= CODE_NONE;
            st_q.rd      <= 1'b0;
            st_q.ack     <= 1'b0;
            st_q.cand    <= '0;
            st_q.mem_v   <= 1'b0;
            st_q.mem_idx <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign match_valid = st_q.match;
    assign match_idx   = st_q.idx;
    assign match_rd    = st_q.rd;
    assign ack_req     = st_q.ack;

    // R12
    ack_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |-> ($past(byte_vld) && !$past(start_det)));

    // R10
    clear_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (!match_valid && match_idx == CODE_NONE && !match_rd));

    // R2
    match_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_valid) |-> ack_req);

    // R7
    gc_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_valid && match_idx == CODE_GC) |-> !match_rd);

    // R10
    hold_until_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_valid && !start_det) |=> (match_valid && $stable(match_idx) && $stable(match_rd)));

endmodule

// File: tb/i2c_addr_matcher_test.sv
module i2c_addr_matcher_test;
    localparam int NS = 3;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_det = 1'b0;
    logic byte_vld = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic [NS-1:0] slot_en = '0;
    logic [NS-1:0] slot_ten = '0;
    logic [NS*10-1:0] slot_addr = '0;
    logic gc_en = 1'b0, devid_en = 1'b0, host_en = 1'b0;
    logic match_valid, match_rd, ack_req;
    logic [IW-1:0] match_idx;

    int total = 0;
    int bad = 0;

    int m_phase = 0;
    logic m_match = 1'b0, m_rd = 1'b0, m_ack = 1'b0, m_mem_v = 1'b0;
    logic [IW-1:0] m_idx = 3'd7;
    logic [NS-1:0] m_cand = '0;
    int m_mem_idx = 0;

    always #4 clk = ~clk;

    i2c_addr_matcher #(.NUM_SLOTS(NS)) uut (
        .clk(clk), .rst_n(rst_n), .start_det(start_det), .byte_vld(byte_vld),
        .byte_data(byte_data), .slot_en(slot_en), .slot_ten(slot_ten),
        .slot_addr(slot_addr), .gc_en(gc_en), .devid_en(devid_en), .host_en(host_en),
        .match_valid(match_valid), .match_idx(match_idx), .match_rd(match_rd),
        .ack_req(ack_req)
    );

    function automatic logic [9:0] sa(int i);
        return slot_addr[i*10 +: 10];
    endfunction

    task automatic chk(string tag, string what, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s got=%0d exp=%0d", tag, what, got, exp);
        end
    endtask

    task automatic check_out(string tag);
        chk(tag, "ack_req", ack_req, m_ack);
        chk(tag, "match_valid", match_valid, m_match);
        chk(tag, "match_idx", match_idx, m_idx);
        chk(tag, "match_rd", match_rd, m_rd);
    endtask

    task automatic model_start();
        m_phase = 1; m_match = 0; m_idx = 3'd7; m_rd = 0; m_ack = 0; m_cand = '0;
    endtask

    task automatic model_byte(logic [7:0] b);
        logic found, res;
        int sel;
        m_ack = 0;
        if (m_phase == 1) begin
            m_phase = 0; found = 0; res = 0; sel = 0;
            for (int i = 0; i < NS; i++) begin
                logic [9:0] a;
                logic h7, rs;
                a  = sa(i);
                h7 = slot_en[i] && !slot_ten[i] && b[7:1] == a[6:0];
                rs = slot_en[i] && slot_ten[i] && b[7:3] == 5'b11110 && b[2:1] == a[9:8]
                     && b[0] && m_mem_v && m_mem_idx == i;
                if (!found && (h7 || rs)) begin
                    found = 1; sel = i; res = rs;
                end
            end
            m_mem_v = 0; m_cand = '0;
            if (found) begin
                m_match = 1; m_idx = IW'(sel); m_rd = b[0]; m_ack = 1; m_mem_v = res;
            end else if (gc_en && b == 8'h00) begin
                m_match = 1; m_idx = 3'd3; m_rd = 0; m_ack = 1;
            end else if (devid_en && b[7:1] == 7'b1111100) begin
                m_match = 1; m_idx = 3'd4; m_rd = b[0]; m_ack = 1;
            end else if (host_en && b == 8'h10) begin
                m_match = 1; m_idx = 3'd5; m_rd = 0; m_ack = 1;
            end else if (!b[0]) begin
                for (int i = 0; i < NS; i++) begin
                    logic [9:0] a;
                    a = sa(i);
                    m_cand[i] = slot_en[i] && slot_ten[i] && b[7:3] == 5'b11110 && b[2:1] == a[9:8];
                end
                if (|m_cand) begin
                    m_ack = 1; m_phase = 2;
                end
            end
        end else if (m_phase == 2) begin
            m_phase = 0; found = 0;
            for (int i = 0; i < NS; i++) begin
                logic [9:0] a;
                a = sa(i);
                if (!found && m_cand[i] && slot_en[i] && slot_ten[i] && b == a[7:0]) begin
                    found = 1; sel = i;
                end
            end
            m_cand = '0;
            if (found) begin
                m_match = 1; m_idx = IW'(sel); m_rd = 0; m_ack = 1; m_mem_v = 1; m_mem_idx = sel;
            end
        end
    endtask

    task automatic do_start(string tag);
        @(negedge clk); start_det = 1'b1; model_start();
        @(negedge clk); start_det = 1'b0;
        check_out(tag);
    endtask

    task automatic do_byte(logic [7:0] b, string tag);
        @(negedge clk); byte_vld = 1'b1; byte_data = b; model_byte(b);
        @(negedge clk); byte_vld = 1'b0;
        check_out(tag);
    endtask

    task automatic set_slot(int i, logic en, logic ten, logic [9:0] a);
        slot_en[i] = en; slot_ten[i] = ten; slot_addr[i*10 +: 10] = a;
    endtask

    initial begin
        #(8 * 150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        gc_en = 1; devid_en = 1; host_en = 1;
        set_slot(0, 1, 0, 10'h02A);
        set_slot(1, 1, 1, 10'h2B5);
        set_slot(2, 0, 0, 10'h02A);
        repeat (3) @(negedge clk);
        // R1 reset state
        m_phase = 0;
        check_out("R1");
        rst_n = 1'b1;
        @(negedge clk);
        do_byte(8'h00, "R1");

        // R2 7-bit read match on slot 0, mixed with 10-bit slot 1
        do_start("R10");
        do_byte(8'h55, "R2");
        chk("R2", "idx literal", match_idx, 0);
        @(negedge clk);
        chk("R12", "ack single pulse", ack_req, 0);
        do_byte(8'h55, "R10");
        do_start("R10");

        // R3 10-bit write then R4 resume
        do_byte(8'hF4, "R3");
        chk("R3", "header ack", ack_req, 1);
        do_byte(8'hB5, "R3");
        chk("R3", "idx literal", match_idx, 1);
        do_start("R4");
        do_byte(8'hF5, "R4");
        chk("R4", "resume rd", match_rd, 1);
        do_start("R3");
        do_byte(8'hF4, "R3");
        do_byte(8'hB4, "R3");
        chk("R3", "bad low no match", match_valid, 0);
        do_start("R4");
        do_byte(8'hF5, "R4");
        chk("R4", "memory cleared", ack_req, 0);

        // R7 R8 R9 reserved addresses
        do_start("R7");
        do_byte(8'h00, "R7");
        chk("R7", "gc code", match_idx, 3);
        do_start("R7");
        do_byte(8'h01, "R7");
        do_start("R8");
        do_byte(8'hF9, "R8");
        chk("R8", "devid code", match_idx, 4);
        do_start("R9");
        do_byte(8'h10, "R9");
        chk("R9", "host code", match_idx, 5);
        do_start("R9");
        do_byte(8'h11, "R9");
        chk("R9", "host read ignored", match_valid, 0);

        // R6 priority, R5 disabled slots
        set_slot(2, 1, 0, 10'h02A);
        do_start("R6");
        do_byte(8'h54, "R6");
        chk("R6", "lowest slot", match_idx, 0);
        slot_en[0] = 1'b0;
        do_start("R5");
        do_byte(8'h54, "R5");
        chk("R5", "slot0 disabled", match_idx, 2);
        set_slot(0, 1, 0, 10'h000);
        do_start("R6");
        do_byte(8'h00, "R6");
        chk("R6", "slot beats gc", match_idx, 0);
        slot_en = '0;
        do_start("R5");
        do_byte(8'h54, "R5");

        // R11 start and byte together
        @(negedge clk); start_det = 1'b1; byte_vld = 1'b1; byte_data = 8'h10; model_start();
        @(negedge clk); start_det = 1'b0; byte_vld = 1'b0;
        check_out("R11");
        do_byte(8'h10, "R11");

        // randomized episodes
        for (int ep = 0; ep < 800; ep++) begin
            logic [7:0] b1, b2;
            int s, r;
            if (ep % 16 == 0) begin
                for (int i = 0; i < NS; i++)
                    set_slot(i, ($urandom % 4) != 0, $urandom % 2, 10'($urandom));
                gc_en = $urandom % 2; devid_en = $urandom % 2; host_en = $urandom % 2;
                if (ep % 32 == 0) slot_addr[29:20] = slot_addr[9:0];
            end
            do_start("R10");
            s = $urandom % NS;
            r = $urandom % 6;
            case (r)
                0: b1 = {sa(s)[6:0], 1'($urandom)};
                1: b1 = {5'b11110, sa(s)[9:8], 1'b0};
                2: b1 = {5'b11110, sa(s)[9:8], 1'b1};
                3: begin
                    case ($urandom % 5)
                        0: b1 = 8'h00;
                        1: b1 = 8'hF8;
                        2: b1 = 8'hF9;
                        3: b1 = 8'h10;
                        default: b1 = 8'h11;
                    endcase
                end
                default: b1 = 8'($urandom);
            endcase
            do_byte(b1, "R6");
            if (m_phase == 2) begin
                b2 = ($urandom % 4 != 0) ? sa($urandom % NS)[7:0] : 8'($urandom);
                do_byte(b2, "R3");
            end
            if ($urandom % 2 == 1) do_byte(8'($urandom), "R10");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule